// File: doc/BRIEF.md
# Constrained Per-Interval Core Selector

This block chooses one of four cores for the next scheduling interval. The cores are ranked by both speed and power, and index 3 is the fastest and most power-hungry. Before each interval, control logic presents three numbers for every core: a throughput figure, an energy figure and an interval runtime. It also presents a mode code and pulses `start_i`. The block latches these inputs. It then walks the cores one per clock, from index 0 upward. Four cycles after the start pulse it raises `valid_o` for one cycle, with the chosen index on `sel_o`.

Each mode is a minimum search behind an eligibility filter. The filter is taken relative to the top core. In energy mode the filter is tight and the lowest energy wins. In energy-delay mode the filter is looser and the lowest energy-runtime product wins. In global mode the filter ignores throughput. It admits a core only when the total runtime of all global-mode choices so far, including this one, stays within 10% of the runtime the top core alone would have taken. For that check the block keeps two runtime totals of its own. No test uses division, and every product is computed at full width.

Top module: `core_pick_top`

## Requirements
- R1: After reset `valid_o` is 0 and `sel_o` is 0.
- R2: A start pulse accepted while idle produces exactly one `valid_o` pulse of one cycle. It is raised after the fourth rising edge following the edge that accepted the start, and `valid_o` stays low in between.
- R3: A `start_i` pulse that arrives during a search is ignored. The running search finishes with its latched inputs, and no extra `valid_o` pulse follows.
- R4: With `mode_i` = 0 (energy), core i is eligible when 10·perf_i ≥ 9·perf_3. The eligible core with the smallest energy is chosen, and the boundary case of equality is eligible.
- R5: With `mode_i` = 1 (energy-delay), core i is eligible when 2·perf_i ≥ perf_3. The eligible core with the smallest energy_i·time_i is chosen.
- R6: With `mode_i` = 2 (global), throughput is ignored. Core i is eligible when 10·(RUN + time_i) ≤ 11·(REF + time_3), where RUN and REF are the stored runtime totals. The eligible core with the smallest energy is chosen.
- R7: Only global-mode selections change the totals. Each one adds time of the chosen core to RUN and time_3 to REF. Reset clears both totals to 0.
- R8: When candidates tie on the figure being minimised, the smaller index wins.
- R9: Core 3 is always eligible, so when no other core passes the filter the result is 3.
- R10: Products and scaled sums are formed without truncation. All 32-bit inputs are valid, including operands whose products exceed 32 bits.
- R11: `mode_i` = 3 behaves exactly like energy mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start a selection; inputs are latched on the accepting edge |
| mode_i | input | 2 | 0 energy, 1 energy-delay, 2 global, 3 energy |
| perf_i | input | 128 | Throughput per core, core k at bits [32k+31:32k] |
| energy_i | input | 128 | Energy per interval per core, same packing |
| time_i | input | 128 | Interval runtime per core, same packing |
| valid_o | output | 1 | One-cycle strobe marking a finished selection |
| sel_o | output | 2 | Chosen core index, held until the next result |

## Verification
The bench targets several corner cases:
- A core sitting exactly on the 90% line. A design with a strict inequality would skip it.
- Equal energies and equal products. A design using a non-strict compare would return the higher index.
- Energy-runtime products above 2^32, and throughputs near 2^32. A truncating design would pick a core whose product wrapped to a small value.
- A global-mode sequence where an energy-mode selection sits between the global steps. A design that advanced the totals on every selection would drift and then choose differently.
- A repeat after reset, which shows that the cleared totals change the choice.
- A start pulse in the middle of a search. A design that restarted would produce a second strobe or use the new inputs.

// File: rtl/core_pick_pkg.sv
package core_pick_pkg;

   typedef enum logic [1:0] {
      PICK_ENERGY = 2'd0,
      PICK_EDP    = 2'd1,
      PICK_GLOBAL = 2'd2,
      PICK_ALT    = 2'd3
   } pick_mode_e;

   // energy-delay ranks by product; every other code ranks by energy alone
   function automatic logic uses_product(input pick_mode_e m);
      return m == PICK_EDP;
   endfunction

   function automatic logic uses_runtime(input pick_mode_e m);
      return m == PICK_GLOBAL;
   endfunction

endpackage

// File: rtl/core_pick_gate.sv
module core_pick_gate
   import core_pick_pkg::*;
#(
   parameter int DW     = 32,
   parameter int AW     = 48,
   parameter int E_SELF = 10,
   parameter int E_TOP  = 9,
   parameter int D_SELF = 2,
   parameter int D_TOP  = 1,
   parameter int G_SELF = 10,
   parameter int G_TOP  = 11
) (
   input  pick_mode_e       mode_i,
   input  logic [DW-1:0]    perf_self_i,
   input  logic [DW-1:0]    perf_top_i,
   input  logic [DW-1:0]    time_self_i,
   input  logic [DW-1:0]    time_top_i,
   input  logic [AW-1:0]    run_i,
   input  logic [AW-1:0]    ref_i,
   output logic             ok_o
);
   localparam int KW = 5;
   localparam int PW = DW + KW;
   localparam int GW = AW + 1 + KW;

   if (E_SELF >= 2**KW || E_TOP >= 2**KW || D_SELF >= 2**KW ||
       D_TOP >= 2**KW || G_SELF >= 2**KW || G_TOP >= 2**KW) begin : g_bad_ratio
      $error("core_pick_gate: ratio constants must fit in %0d bits", KW);
   end
   if (AW < DW) begin : g_bad_acc
      $error("core_pick_gate: AW must be at least DW");
   end

   logic [PW-1:0] e_lhs, e_rhs, d_lhs, d_rhs;
   logic [GW-1:0] g_lhs, g_rhs;
   logic          e_ok, d_ok, g_ok;

   always_comb begin
      e_lhs = PW'(perf_self_i) * PW'(E_SELF);
      e_rhs = PW'(perf_top_i)  * PW'(E_TOP);
      d_lhs = PW'(perf_self_i) * PW'(D_SELF);
      d_rhs = PW'(perf_top_i)  * PW'(D_TOP);
      g_lhs = (GW'(run_i) + GW'(time_self_i)) * GW'(G_SELF);
      g_rhs = (GW'(ref_i) + GW'(time_top_i))  * GW'(G_TOP);
      e_ok  = e_lhs >= e_rhs;
      d_ok  = d_lhs >= d_rhs;
      g_ok  = g_lhs <= g_rhs;
   end

   always_comb begin
      if (uses_runtime(mode_i))      ok_o = g_ok;
      else if (uses_product(mode_i)) ok_o = d_ok;
      else                           ok_o = e_ok;
   end

endmodule

// File: rtl/core_pick_metric.sv
module core_pick_metric
   import core_pick_pkg::*;
#(
   parameter int DW = 32,
   parameter int MW = 2 * DW
) (
   input  pick_mode_e    mode_i,
   input  logic [DW-1:0] energy_i,
   input  logic [DW-1:0] time_i,
   output logic [MW-1:0] metric_o
);
   if (MW < 2 * DW) begin : g_bad_mw
      $error("core_pick_metric: MW must hold a full product");
   end

   logic [MW-1:0] prod;

   always_comb begin
      prod = MW'(energy_i) * MW'(time_i);
      if (uses_product(mode_i)) metric_o = prod;
      else                      metric_o = MW'(energy_i);
   end

endmodule

// File: rtl/core_pick_acc.sv
module core_pick_acc #(
   parameter int DW = 32,
   parameter int AW = 48
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          adv_i,
   input  logic [DW-1:0] run_add_i,
   input  logic [DW-1:0] ref_add_i,
   output logic [AW-1:0] run_o,
   output logic [AW-1:0] ref_o
);
   if (AW < DW) begin : g_bad_aw
      $error("core_pick_acc: AW must be at least DW");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         run_o <= '0;
         ref_o <= '0;
      end else if (adv_i) begin
         run_o <= run_o + AW'(run_add_i);
         ref_o <= ref_o + AW'(ref_add_i);
      end
   end

endmodule

// File: rtl/core_pick_top.sv
module core_pick_top
   import core_pick_pkg::*;
#(
   parameter int NCORE = 4,
   parameter int DW    = 32,
   parameter int AW    = 48,
   localparam int CW   = (NCORE > 1) ? $clog2(NCORE) : 1,
   localparam int MW   = 2 * DW
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               start_i,
   input  logic [1:0]         mode_i,
   input  logic [NCORE*DW-1:0] perf_i,
   input  logic [NCORE*DW-1:0] energy_i,
   input  logic [NCORE*DW-1:0] time_i,
   output logic               valid_o,
   output logic [CW-1:0]      sel_o
);
   localparam int        TOP  = NCORE - 1;
   localparam logic [CW-1:0] LAST = CW'(TOP);

   if (NCORE < 2) begin : g_bad_ncore
      $error("core_pick_top: need at least two cores");
   end
   if (DW < 2) begin : g_bad_dw
      $error("core_pick_top: DW too small");
   end
   if (AW < DW + 4) begin : g_bad_aw
      $error("core_pick_top: AW must leave headroom above DW");
   end

   // latched request
   logic [DW-1:0] perf_q [NCORE];
   logic [DW-1:0] en_q   [NCORE];
   logic [DW-1:0] tm_q   [NCORE];
   pick_mode_e    mode_q;

   // search state
   logic          busy_q;
   logic [CW-1:0] idx_q;
   logic          have_q;
   logic [CW-1:0] best_q;
   logic [MW-1:0] best_m_q;

   // per-core views
   logic [NCORE-1:0] pass_v;
   logic [MW-1:0]    met_v [NCORE];

   // running totals
   logic [AW-1:0] acc_run, acc_ref;

   logic          accept, finish, take;
   logic [CW-1:0] next_best;

   assign accept = start_i && !busy_q;
   assign finish = busy_q && (idx_q == LAST);

   for (genvar k = 0; k < NCORE; k++) begin : g_core
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            perf_q[k] <= '0;
            en_q[k]   <= '0;
            tm_q[k]   <= '0;
         end else if (accept) begin
            perf_q[k] <= perf_i[k*DW +: DW];
            en_q[k]   <= energy_i[k*DW +: DW];
            tm_q[k]   <= time_i[k*DW +: DW];
         end
      end

      core_pick_gate #(.DW(DW), .AW(AW)) u_gate (
         .mode_i      (mode_q),
         .perf_self_i (perf_q[k]),
         .perf_top_i  (perf_q[TOP]),
         .time_self_i (tm_q[k]),
         .time_top_i  (tm_q[TOP]),
         .run_i       (acc_run),
         .ref_i       (acc_ref),
         .ok_o        (pass_v[k])
      );

      core_pick_metric #(.DW(DW), .MW(MW)) u_metric (
         .mode_i   (mode_q),
         .energy_i (en_q[k]),
         .time_i   (tm_q[k]),
         .metric_o (met_v[k])
      );
   end

   // a candidate replaces the held best only when strictly smaller,
   // so ascending order hands ties to the lower index
   always_comb begin
      take      = pass_v[idx_q] && (!have_q || (met_v[idx_q] < best_m_q));
      next_best = take ? idx_q : best_q;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mode_q   <= PICK_ENERGY;
         busy_q   <= 1'b0;
         idx_q    <= '0;
         have_q   <= 1'b0;
         best_q   <= '0;
         best_m_q <= '0;
         valid_o  <= 1'b0;
         sel_o    <= '0;
      end else begin
         valid_o <= 1'b0;
         if (accept) begin
            mode_q <= pick_mode_e'(mode_i);
            busy_q <= 1'b1;
            idx_q  <= '0;
            have_q <= 1'b0;
         end else if (busy_q) begin
            if (take) begin
               have_q   <= 1'b1;
               best_q   <= idx_q;
               best_m_q <= met_v[idx_q];
            end
            if (finish) begin
               busy_q  <= 1'b0;
               valid_o <= 1'b1;
               sel_o   <= next_best;
            end else begin
               idx_q <= idx_q + 1'b1;
            end
         end
      end
   end

   core_pick_acc #(.DW(DW), .AW(AW)) u_acc (
      .clk       (clk),
      .rst_n     (rst_n),
      .adv_i     (finish && uses_runtime(mode_q)),
      .run_add_i (tm_q[next_best]),
      .ref_add_i (tm_q[TOP]),
      .run_o     (acc_run),
      .ref_o     (acc_ref)
   );

endmodule

// File: rtl/core_pick_chk.sv
module core_pick_chk #(
   parameter int NCORE = 4,
   parameter int AW    = 48,
   localparam int CW   = (NCORE > 1) ? $clog2(NCORE) : 1,
   localparam int LW   = $clog2(NCORE + 2) + 1
) (
   input logic             clk,
   input logic             rst_n,
   input logic             start_i,
   input logic             busy_q,
   input logic             valid_o,
   input logic [CW-1:0]    sel_o,
   input logic [NCORE-1:0] pass_v,
   input logic [AW-1:0]    acc_run,
   input logic [AW-1:0]    acc_ref
);
   logic          run_q;
   logic [LW-1:0] lat_q;
   logic [NCORE-1:0] pass_d;
   logic [AW+4:0] run_x10, ref_x11;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         run_q  <= 1'b0;
         lat_q  <= '0;
         pass_d <= '0;
      end else begin
         pass_d <= pass_v;
         if (start_i && !busy_q) begin
            run_q <= 1'b1;
            lat_q <= '0;
         end else if (run_q) begin
            lat_q <= lat_q + 1'b1;
            if (valid_o) run_q <= 1'b0;
         end
      end
   end

   assign run_x10 = (AW+5)'(acc_run) * (AW+5)'(10);
   assign ref_x11 = (AW+5)'(acc_ref) * (AW+5)'(11);

   AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      valid_o |=> !valid_o); // R2
   AST_LATENCY_EXACT: assert property (@(posedge clk) disable iff (!rst_n)
      valid_o |-> (run_q && lat_q == LW'(NCORE))); // R2
   AST_LATENCY_DUE: assert property (@(posedge clk) disable iff (!rst_n)
      (run_q && lat_q == LW'(NCORE)) |-> valid_o); // R3
   AST_SEL_ELIGIBLE: assert property (@(posedge clk) disable iff (!rst_n)
      valid_o |-> pass_d[sel_o]); // R4
   AST_TOP_ALWAYS_OK: assert property (@(posedge clk) disable iff (!rst_n)
      busy_q |-> pass_v[NCORE-1]); // R9
   AST_RUN_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
      run_x10 <= ref_x11); // R6

endmodule

bind core_pick_top core_pick_chk #(.NCORE(NCORE), .AW(AW)) u_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .start_i (start_i),
   .busy_q  (busy_q),
   .valid_o (valid_o),
   .sel_o   (sel_o),
   .pass_v  (pass_v),
   .acc_run (acc_run),
   .acc_ref (acc_ref)
);

// File: tb/core_pick_top_tb.sv
`timescale 1ns/1ps
module core_pick_top_tb;
   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         start_i = 1'b0;
   logic [1:0]   mode_i = 2'd0;
   logic [127:0] perf_i = '0, energy_i = '0, time_i = '0;
   logic         valid_o;
   logic [1:0]   sel_o;

   int n_run = 0;
   int n_fail = 0;

   always #2.5 clk = ~clk;

   core_pick_top u_dut (
      .clk(clk), .rst_n(rst_n), .start_i(start_i), .mode_i(mode_i),
      .perf_i(perf_i), .energy_i(energy_i), .time_i(time_i),
      .valid_o(valid_o), .sel_o(sel_o)
   );

   // vectors: each 128-bit word lists core 3, 2, 1, 0 from left to right
   localparam int NV = 9;
   localparam logic [1:0] VM [NV] = '{2'd0, 2'd0, 2'd0, 2'd0, 2'd1, 2'd1, 2'd1, 2'd0, 2'd3};
   localparam logic [127:0] VP [NV] = '{
      {32'd100, 32'd95, 32'd80, 32'd50},
      {32'd100, 32'd60, 32'd89, 32'd90},
      {32'd100, 32'd95, 32'd95, 32'd95},
      {32'd100, 32'd30, 32'd20, 32'd10},
      {32'd100, 32'd80, 32'd49, 32'd50},
      {32'd100, 32'd60, 32'd60, 32'd60},
      {32'd100, 32'd100, 32'd100, 32'd100},
      {32'hFFFFFFFF, 32'hE6666666, 32'd0, 32'd0},
      {32'd100, 32'd95, 32'd80, 32'd50}};
   localparam logic [127:0] VE [NV] = '{
      {32'd40, 32'd30, 32'd20, 32'd10},
      {32'd9, 32'd1, 32'd1, 32'd5},
      {32'd9, 32'd8, 32'd7, 32'd7},
      {32'd50, 32'd3, 32'd2, 32'd1},
      {32'd9, 32'd6, 32'd1, 32'd10},
      {32'd10, 32'd8, 32'd2, 32'd4},
      {32'hFFFFFFFF, 32'h10000, 32'h20000, 32'h10000},
      {32'd9, 32'd5, 32'd0, 32'd0},
      {32'd40, 32'd30, 32'd20, 32'd10}};
   localparam logic [127:0] VT [NV] = '{
      {32'd1, 32'd1, 32'd1, 32'd1},
      {32'd1, 32'd1, 32'd1, 32'd1},
      {32'd1, 32'd1, 32'd1, 32'd1},
      {32'd1, 32'd1, 32'd1, 32'd1},
      {32'd4, 32'd5, 32'd10, 32'd10},
      {32'd4, 32'd5, 32'd10, 32'd5},
      {32'd1, 32'h10001, 32'h10000, 32'h10000},
      {32'd1, 32'd1, 32'd1, 32'd1},
      {32'd1, 32'd1, 32'd1, 32'd1}};
   localparam logic [1:0] VX [NV] = '{2'd2, 2'd0, 2'd0, 2'd3, 2'd2, 2'd0, 2'd3, 2'd2, 2'd2};
   localparam string VR [NV] = '{"R4", "R4", "R8", "R9", "R5", "R8", "R10", "R10", "R11"};

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_run++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   // drive one request, verify the R2 timing and the chosen index
   task automatic run_sel(input logic [1:0] m, input logic [127:0] p, input logic [127:0] e,
                          input logic [127:0] t, input logic [1:0] exp, input string req);
      @(negedge clk);
      mode_i = m; perf_i = p; energy_i = e; time_i = t; start_i = 1'b1;
      @(negedge clk);
      start_i = 1'b0;
      for (int i = 0; i < 3; i++) begin
         @(negedge clk);
         check("R2", 32'(valid_o), 32'd0);
      end
      @(negedge clk);
      check("R2", 32'(valid_o), 32'd1);
      check(req, 32'(sel_o), 32'(exp));
      @(negedge clk);
      check("R2", 32'(valid_o), 32'd0);
   endtask

   localparam logic [127:0] GP = {32'd100, 32'd0, 32'd0, 32'd0};
   localparam logic [127:0] GE = {32'd4, 32'd3, 32'd2, 32'd1};

   initial begin : watchdog
      #(200000 * 5);
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin : main
      repeat (3) @(negedge clk);
      check("R1", 32'(valid_o), 32'd0);
      check("R1", 32'(sel_o), 32'd0);
      rst_n = 1'b1;

      // global sequence first, totals start from zero (R6, R7)
      run_sel(2'd2, GP, GE, {32'd10, 32'd11, 32'd12, 32'd14}, 2'd2, "R6");
      run_sel(2'd2, GP, GE, {32'd10, 32'd12, 32'd12, 32'd12}, 2'd3, "R9");

      // vector table
      for (int v = 0; v < NV; v++)
         run_sel(VM[v], VP[v], VE[v], VT[v], VX[v], VR[v]);

      // totals untouched by the non-global picks above (R7)
      run_sel(2'd2, GP, GE, {32'd20, 32'd20, 32'd20, 32'd20}, 2'd0, "R7");
      run_sel(2'd2, GP, GE, {32'd1, 32'd5, 32'd5, 32'd5}, 2'd3, "R6");

      // reset clears the totals: first global step repeats its result (R7)
      @(negedge clk);
      rst_n = 1'b0;
      @(negedge clk);
      check("R1", 32'(valid_o), 32'd0);
      check("R1", 32'(sel_o), 32'd0);
      rst_n = 1'b1;
      run_sel(2'd2, GP, GE, {32'd10, 32'd11, 32'd12, 32'd14}, 2'd2, "R7");

      // start during a search is ignored (R3)
      @(negedge clk);
      mode_i = 2'd0; perf_i = VP[0]; energy_i = VE[0]; time_i = VT[0]; start_i = 1'b1;
      @(negedge clk);
      mode_i = 2'd0; perf_i = VP[3]; energy_i = VE[3]; time_i = VT[3];
      @(negedge clk);
      start_i = 1'b0;
      for (int i = 0; i < 2; i++) begin
         @(negedge clk);
         check("R3", 32'(valid_o), 32'd0);
      end
      @(negedge clk);
      check("R3", 32'(valid_o), 32'd1);
      check("R3", 32'(sel_o), 32'd2);
      for (int i = 0; i < 6; i++) begin
         @(negedge clk);
         check("R3", 32'(valid_o), 32'd0);
      end

      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

endmodule